// File: doc/BRIEF.md
# Two-Port Semaphore Flag Arbiter

This block holds a bank of hardware semaphore flags that two requesters share, the way a pair of processors shares a two-sided memory. Each flag is a single busy/free bit. A requester addresses one flag by its index and asks either to take it or to hand it back. A take request gets a one-shot answer. If the flag was free, the answer is granted and the flag becomes busy in the same operation. If the flag was already busy, the answer is denied and the flag is left as it was. A hand-back request makes the flag free. The bank never records which requester holds a flag, so either side may free any flag.

Only one request is carried out per cycle. When both ports ask in the same cycle, the port that holds priority is served and the other port's request waits. Priority always moves to the port that was not just served. A requester that polls a busy flag on every cycle therefore cannot keep the other side's hand-back from getting through. A port raises its request and holds it until its accept output is high. One cycle after the accept, a response strobe arrives carrying the grant bit.

The number of flags is a parameter and must be at least three. The default is eight, which gives a 3-bit index.

Top module: `sema_arbiter`

## Requirements
- R1: A take request (op bit 0) on a free flag is answered with grant=1, and that flag is busy from the next cycle onward.
- R2: A take request on a busy flag is answered with grant=0, and the flag stays busy.
- R3: A hand-back request (op bit 1) leaves the addressed flag free and is answered with grant=1.
- R4: A port's rsp_vld is high in exactly the cycle after a cycle in which its req_acc was high, and low in every other cycle.
- R5: No more than one port is accepted in any cycle, and a port is accepted only while its req_vld is high.
- R6: When both ports request in the same cycle, only the port that holds priority is accepted.
- R7: After a port has been served, the other port holds priority. A pending request from the other port is therefore accepted in the next cycle, even if the served port requests again.
- R8: After reset every flag is free, port 0 holds priority, and neither rsp_vld is high.
- R9: Flags do not record an owner. A hand-back from either port frees a flag that the other port took.
- R10: A request changes only the flag its index selects. All other flags keep their state.
- R11: A request from a port is accepted in the same cycle whenever the other port is not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| p0_req_vld | input | 1 | Port 0 request present; held until accepted |
| p0_req_rel | input | 1 | Port 0 operation: 0 take, 1 hand back |
| p0_req_idx | input | IDX_W (3) | Port 0 flag index |
| p0_req_acc | output | 1 | Port 0 request accepted this cycle |
| p0_rsp_vld | output | 1 | Port 0 response strobe, one cycle after accept |
| p0_rsp_grant | output | 1 | Port 0 answer: 1 granted, 0 denied |
| p1_req_vld | input | 1 | Port 1 request present; held until accepted |
| p1_req_rel | input | 1 | Port 1 operation: 0 take, 1 hand back |
| p1_req_idx | input | IDX_W (3) | Port 1 flag index |
| p1_req_acc | output | 1 | Port 1 request accepted this cycle |
| p1_rsp_vld | output | 1 | Port 1 response strobe, one cycle after accept |
| p1_rsp_grant | output | 1 | Port 1 answer: 1 granted, 0 denied |

## Verification
The properties assume that each port keeps its request, operation and index steady from the cycle it raises req_vld until the cycle req_acc answers. They also assume that indices stay below the flag count. The alternation property relies on the served port's reassertion being treated as a fresh request. The stimulus drives every field on the falling edge and only changes a port's request after it has seen the accept. It sweeps only the legal index range, so every input the assertions see stays inside these assumptions.

// File: rtl/sema_pkg.sv
// Shared definitions for the two-port semaphore flag arbiter.
// Assumes: exactly two requesting ports.
package sema_pkg;
    localparam int unsigned NUM_PORTS = 2;

    typedef enum logic {
        SEMA_TAKE = 1'b0,
        SEMA_GIVE = 1'b1
    } sema_op_e;
endpackage

// File: rtl/sema_pick.sv
// Chooses which port is served each cycle and rotates priority.
// Assumes: requests stay asserted until accepted; at most one port is served.
module sema_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] vld,
    output logic [1:0] acc,
    output logic       win,
    output logic       fire
);
    logic prio_q;

    // Winner: the priority port if both request, otherwise the one requesting.
    always_comb begin
        fire = |vld;
        win  = (vld[0] && vld[1]) ? prio_q : vld[1];
        acc  = fire ? (2'b01 << win) : 2'b00;
    end

    // Priority moves to the port that was not just served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_q <= 1'b0;
        else if (fire)
            prio_q <= ~win;
    end
endmodule

// File: rtl/sema_flags.sv
// Bank of ownerless busy/free flags; one flag is updated per served request.
// Assumes: NUM_SEMA >= 3; an index at or above NUM_SEMA touches no flag.
module sema_flags #(
    parameter int unsigned NUM_SEMA = 8,
    parameter int unsigned IDX_W    = $clog2(NUM_SEMA)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  sema_pkg::sema_op_e      op,
    input  logic [IDX_W-1:0]        idx,
    output logic [NUM_SEMA-1:0]     flags,
    output logic                    in_range,
    output logic                    was_busy
);
    // Index check and the current state of the addressed flag.
    always_comb begin
        in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_SEMA));
        was_busy = in_range && flags[idx];
    end

    for (genvar i = 0; i < NUM_SEMA; i++) begin : g_flag
        logic hit;
        assign hit = fire && (idx == IDX_W'(i));

        // One flag: cleared on reset or hand-back, set on take.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (hit)
                flags[i] <= (op == sema_pkg::SEMA_TAKE);
        end
    end
endmodule

// File: rtl/sema_resp.sv
// Per-port response registers: a strobe and grant bit one cycle after accept.
// Assumes: outcome is valid for the port accepted in the same cycle.
module sema_resp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] acc,
    input  logic       outcome,
    output logic [1:0] rsp_vld,
    output logic [1:0] rsp_grant
);
    for (genvar p = 0; p < sema_pkg::NUM_PORTS; p++) begin : g_port
        // Register this port's answer for one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_vld[p]   <= 1'b0;
                rsp_grant[p] <= 1'b0;
            end else begin
                rsp_vld[p]   <= acc[p];
                rsp_grant[p] <= acc[p] && outcome;
            end
        end
    end
endmodule

// File: rtl/sema_arbiter.sv
// Two-port semaphore flag arbiter: take/hand-back on indexed ownerless flags,
// one request per cycle, priority alternating after each served request.
// Assumes: each port holds its request fields steady until req_acc.
module sema_arbiter #(
    parameter  int unsigned NUM_SEMA = 8,
    localparam int unsigned IDX_W    = $clog2(NUM_SEMA)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p0_req_vld,
    input  logic             p0_req_rel,
    input  logic [IDX_W-1:0] p0_req_idx,
    output logic             p0_req_acc,
    output logic             p0_rsp_vld,
    output logic             p0_rsp_grant,
    input  logic             p1_req_vld,
    input  logic             p1_req_rel,
    input  logic [IDX_W-1:0] p1_req_idx,
    output logic             p1_req_acc,
    output logic             p1_rsp_vld,
    output logic             p1_rsp_grant
);
    logic [1:0]          acc;
    logic                win;
    logic                fire;
    sema_pkg::sema_op_e  sel_op;
    logic [IDX_W-1:0]    sel_idx;
    logic [NUM_SEMA-1:0] flag_q;
    logic                in_range;
    logic                was_busy;
    logic                outcome;
    logic [1:0]          rsp_vld;
    logic [1:0]          rsp_grant;

    sema_pick u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  ({p1_req_vld, p0_req_vld}),
        .acc  (acc),
        .win  (win),
        .fire (fire)
    );

    // Route the served port's operation and index to the flag bank.
    always_comb begin
        sel_op  = sema_pkg::sema_op_e'(win ? p1_req_rel : p0_req_rel);
        sel_idx = win ? p1_req_idx : p0_req_idx;
    end

    sema_flags #(.NUM_SEMA(NUM_SEMA), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .op      (sel_op),
        .idx     (sel_idx),
        .flags   (flag_q),
        .in_range(in_range),
        .was_busy(was_busy)
    );

    // Answer: take is granted on a free flag, hand-back always on a legal index.
    always_comb begin
        outcome = (sel_op == sema_pkg::SEMA_GIVE) ? in_range : (in_range && !was_busy);
    end

    sema_resp u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .outcome  (outcome),
        .rsp_vld  (rsp_vld),
        .rsp_grant(rsp_grant)
    );

    // Fan the packed internal vectors out to the per-port pins.
    always_comb begin
        p0_req_acc   = acc[0];
        p1_req_acc   = acc[1];
        p0_rsp_vld   = rsp_vld[0];
        p1_rsp_vld   = rsp_vld[1];
        p0_rsp_grant = rsp_grant[0];
        p1_rsp_grant = rsp_grant[1];
    end
endmodule

// File: rtl/sema_arbiter_chk.sv
// Property checker for sema_arbiter, attached by bind.
// Assumes: request fields are stable while a request waits for acceptance.
module sema_arbiter_chk #(
    parameter int unsigned NUM_SEMA = 8,
    parameter int unsigned IDX_W    = $clog2(NUM_SEMA)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                p0_req_vld,
    input logic                p0_req_rel,
    input logic [IDX_W-1:0]    p0_req_idx,
    input logic                p0_req_acc,
    input logic                p0_rsp_vld,
    input logic                p0_rsp_grant,
    input logic                p1_req_vld,
    input logic                p1_req_rel,
    input logic [IDX_W-1:0]    p1_req_idx,
    input logic                p1_req_acc,
    input logic                p1_rsp_vld,
    input logic                p1_rsp_grant,
    input logic [NUM_SEMA-1:0] flag_q
);
    p_single_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_req_acc && p1_req_acc));
    p_acc_needs_vld0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        p0_req_acc |-> p0_req_vld);
    p_acc_needs_vld1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        p1_req_acc |-> p1_req_vld);

    p_rsp_after_acc0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p0_req_acc |=> p0_rsp_vld);
    p_no_rsp_idle0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_req_acc |=> !p0_rsp_vld);
    p_rsp_after_acc1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p1_req_acc |=> p1_rsp_vld);
    p_no_rsp_idle1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_req_acc |=> !p1_rsp_vld);

    p_lone_served0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_vld && !p1_req_vld) |-> p0_req_acc);
    p_lone_served1_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req_vld && !p0_req_vld) |-> p1_req_acc);

    p_turn_to1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        p0_req_acc |=> (p1_req_vld |-> p1_req_acc));
    p_turn_to0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        p1_req_acc |=> (p0_req_vld |-> p0_req_acc));

    p_take_answer0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_acc && !p0_req_rel) |=> (p0_rsp_grant == !$past(flag_q[p0_req_idx])));
    p_take_answer1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req_acc && !p1_req_rel) |=> (p1_rsp_grant == !$past(flag_q[p1_req_idx])));
    p_take_locks0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_acc && !p0_req_rel) |=> flag_q[$past(p0_req_idx)]);
    p_take_locks1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req_acc && !p1_req_rel) |=> flag_q[$past(p1_req_idx)]);

    p_give_frees0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_acc && p0_req_rel) |=> (!flag_q[$past(p0_req_idx)] && p0_rsp_grant));
    p_give_frees1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req_acc && p1_req_rel) |=> (!flag_q[$past(p1_req_idx)] && p1_rsp_grant));

    p_idle_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!p0_req_vld && !p1_req_vld) |=> $stable(flag_q));
    p_one_flag_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(flag_q ^ $past(flag_q)) <= 1));
endmodule

bind sema_arbiter sema_arbiter_chk #(.NUM_SEMA(NUM_SEMA), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .p0_req_vld  (p0_req_vld),
    .p0_req_rel  (p0_req_rel),
    .p0_req_idx  (p0_req_idx),
    .p0_req_acc  (p0_req_acc),
    .p0_rsp_vld  (p0_rsp_vld),
    .p0_rsp_grant(p0_rsp_grant),
    .p1_req_vld  (p1_req_vld),
    .p1_req_rel  (p1_req_rel),
    .p1_req_idx  (p1_req_idx),
    .p1_req_acc  (p1_req_acc),
    .p1_rsp_vld  (p1_rsp_vld),
    .p1_rsp_grant(p1_rsp_grant),
    .flag_q      (flag_q)
);

// File: tb/sema_arbiter_bench.sv
`timescale 1ns/1ps
module sema_arbiter_bench;
    localparam int NS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] vld = 2'b00;
    logic [1:0] rel = 2'b00;
    logic [2:0] idx [2];
    logic [1:0] acc, rv, rg;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  lock_m [NS];
    int  prio_m = 0;

    always #5 clk = ~clk;

    sema_arbiter u_sema_arbiter (
        .clk(clk), .rst_n(rst_n),
        .p0_req_vld(vld[0]), .p0_req_rel(rel[0]), .p0_req_idx(idx[0]),
        .p0_req_acc(acc[0]), .p0_rsp_vld(rv[0]), .p0_rsp_grant(rg[0]),
        .p1_req_vld(vld[1]), .p1_req_rel(rel[1]), .p1_req_idx(idx[1]),
        .p1_req_acc(acc[1]), .p1_rsp_vld(rv[1]), .p1_rsp_grant(rg[1])
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected answer from the requirement model; updates model flag state.
    function automatic bit model_apply(input bit r, input int i);
        bit g;
        if (r) begin
            lock_m[i] = 1'b0;
            return 1'b1;
        end
        g = !lock_m[i];
        lock_m[i] = 1'b1;
        return g;
    endfunction

    function automatic string ans_tag(input bit r, input bit g);
        if (r) return "R3 hand-back answer";
        return g ? "R1 take on free flag" : "R2 take on busy flag";
    endfunction

    // One request from a single port while the other is idle.
    task automatic xact(input int p, input bit r, input int i, input string tag);
        bit eg;
        @(negedge clk);
        vld[p] = 1'b1; rel[p] = r; idx[p] = 3'(i);
        #1;
        chk(acc[p] == 1'b1, "R11 lone request accepted", acc[p], 1);
        chk(acc[1-p] == 1'b0, "R5 idle port not accepted", acc[1-p], 0);
        eg = model_apply(r, i);
        prio_m = 1 - p;
        @(negedge clk);
        vld[p] = 1'b0;
        chk(rv[p] == 1'b1, "R4 strobe after accept", rv[p], 1);
        chk(rv[1-p] == 1'b0, "R4 no strobe without accept", rv[1-p], 0);
        chk(rg[p] == eg, (tag == "") ? ans_tag(r, eg) : tag, rg[p], eg);
    endtask

    // Both ports request together; winner re-requests at once, loser must still get in.
    task automatic duel(input bit r0, input int i0, input bit r1, input int i1);
        int w, l;
        bit ew, el, ew2;
        bit rr [2];
        int ii [2];
        rr[0] = r0; rr[1] = r1; ii[0] = i0; ii[1] = i1;
        @(negedge clk);
        vld = 2'b11; rel = {r1, r0}; idx[0] = 3'(i0); idx[1] = 3'(i1);
        #1;
        w = prio_m; l = 1 - w;
        chk(acc == 2'(1 << w), "R6 only priority port accepted", acc, 1 << w);
        ew = model_apply(rr[w], ii[w]);
        @(negedge clk);
        chk(rv[w] == 1'b1 && rv[l] == 1'b0, "R4 strobe for winner only", rv, 1 << w);
        chk(rg[w] == ew, ans_tag(rr[w], ew), rg[w], ew);
        rel[w] = 1'b0;            // winner polls again with a take
        #1;
        chk(acc == 2'(1 << l), "R7 waiting port served next", acc, 1 << l);
        el = model_apply(rr[l], ii[l]);
        @(negedge clk);
        vld[l] = 1'b0;
        chk(rv[l] == 1'b1 && rg[l] == el, "R7 waiting port answer", {rv[l], rg[l]}, {1'b1, el});
        #1;
        chk(acc == 2'(1 << w), "R7 priority back to repeat requester", acc, 1 << w);
        ew2 = model_apply(1'b0, ii[w]);
        prio_m = l;
        @(negedge clk);
        vld[w] = 1'b0;
        chk(rg[w] == ew2, ans_tag(1'b0, ew2), rg[w], ew2);
    endtask

    initial begin
        idx[0] = 3'd0; idx[1] = 3'd0;
        for (int i = 0; i < NS; i++) lock_m[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(rv == 2'b00, "R8 no strobe after reset", rv, 0);
        // R8: first contest after reset goes to port 0.
        @(negedge clk);
        vld = 2'b11; rel = 2'b00; idx[0] = 3'd7; idx[1] = 3'd6;
        #1;
        chk(acc == 2'b01, "R8 port 0 holds priority after reset", acc, 1);
        @(negedge clk);
        vld[0] = 1'b0;
        chk(rg[0] == 1'b1, "R8 flag free after reset", rg[0], 1);
        @(negedge clk);
        vld[1] = 1'b0;
        chk(rg[1] == 1'b1, "R8 flag free after reset", rg[1], 1);
        lock_m[7] = 1'b1; lock_m[6] = 1'b1; prio_m = 0;
        xact(0, 1'b1, 7, ""); xact(1, 1'b1, 6, "");
        // R8: every flag starts free.
        for (int i = 0; i < NS; i++) xact(i % 2, 1'b0, i, "R8 all flags free after reset");
        for (int i = 0; i < NS; i++) xact((i + 1) % 2, 1'b1, i, "");
        // Sweep: every 4-step op/port pattern on every index.
        for (int i = 0; i < NS; i++)
            for (int pat = 0; pat < 16; pat++)
                for (int k = 0; k < 4; k++)
                    xact(((pat >> k) & 1) ^ (i & 1) ^ (k & 1), bit'((pat >> k) & 1), i, "");
        // R9: ownerless hand-back.
        xact(0, 1'b0, 5, "");
        xact(1, 1'b1, 5, "R9 other port frees flag");
        xact(0, 1'b0, 5, "R9 flag free after foreign hand-back");
        // Contest sweep, including same-index collisions.
        for (int a = 0; a < 32; a++)
            duel(bit'(a & 1), (a >> 2) & 7, bit'((a >> 1) & 1), ((a >> 4) & 1) ? (a >> 2) & 7 : ((a >> 2) + 3) & 7);
        // R10: probe every flag and compare with the model.
        for (int i = 0; i < NS; i++) begin
            bit was;
            was = lock_m[i];
            xact(i % 2, 1'b0, i, was ? "R10 neighbour state busy" : "R10 neighbour state free");
        end
        @(negedge clk);
        chk(rv == 2'b00, "R4 quiet when idle", rv, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule